// File: doc/BRIEF.md
# Clock output power-management controller

This block is the control core of a small two-output clock buffer. It decides, for each of two differential clock outputs and for one single-ended reference output, whether the output runs, is parked at fixed levels, is switched off, or floats. It also fixes the device's serial-bus slave address and selects the spread-spectrum setting passed to the clock generator. The serial-bus engine, PLL, oscillator and pad drivers sit outside. Configuration bits arrive as plain parallel inputs from a register file in the same clock domain.

Pin inputs (power-good/power-down, per-output enables, PLL lock, address select and spread select) are asynchronous. They pass through a two-flop synchronizer on the rising edge of `clk`, the clock that the gated outputs carry. Every output mode is then registered on the falling edge, so a gate opens or closes only while the clock is low and never cuts a pulse short. A sticky "power-good seen" flag, cleared only by reset, controls the reference output's first release and the one-time address capture.

Top module: `clkout_pwr_ctrl`

## Requirements
- R1: `addr_o` reads 7'b1101000 from reset. At the first synchronized high level of `pwrgd_i` it takes 7'b1101000 if `addr_sel_i` is 0 and 7'b1101010 if it is 1, and it appears on the next rising edge. Later values of `addr_sel_i` and later power-good cycles leave it unchanged.
- R2: `ref_mode_o` is high-impedance (2'b11) from reset until the synchronized `pwrgd_i` is seen high for the first time.
- R3: After power-good has been seen, while synchronized `pwrgd_i` is low, `ref_mode_o` is off (2'b00), or running (2'b01) when `cfg_ref_pd_run_i` is 1.
- R4: While synchronized `pwrgd_i` is high, `ref_mode_o` is running (2'b01), whatever the lock and enable inputs are.
- R5: While synchronized `pwrgd_i` is low, every differential output's mode field (bits 2i+1:2i of `bclk_mode_o`) is park (2'b10), and its level field in `bclk_lvl_o` equals `cfg_park_lvl_i` (bit 0 true level, bit 1 complement level). In every other mode the level field is 2'b00.
- R6: With power-good and lock both high, output i is running (2'b01) only when `oe_pin_i[i]` and `cfg_oe_i[i]` are both 1. Otherwise it is off (2'b00). The two outputs are independent.
- R7: With power-good high and synchronized `pll_lock_i` low, both differential outputs are off (2'b00). A differential output is never high-impedance.
- R8: `bclk_gate_o[i]` is 1 exactly when output i's mode is running, and `ref_gate_o` is 1 exactly when `ref_mode_o` is running.
- R9: A pin change seen at rising edge k reaches the output modes at the falling edge after rising edge k+2. A configuration change takes effect at the next falling edge. No mode changes while `clk` is high.
- R10: `spread_o` follows the synchronized `ss_pin_i` when `cfg_ss_from_reg_i` is 0 and follows `cfg_ss_i` when it is 1. The codes are 2'b00 off, 2'b01 -0.25% and 2'b10 -0.5%, and the unused code 2'b11 becomes 2'b00.
- R11: Only reset clears the power-good-seen state. After a new reset the reference output floats again and the address is captured again at the next first power-good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock; pins synchronized on rise, modes updated on fall |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwrgd_i | input | 1 | Power-good (high) / power-down (low) pin |
| oe_pin_i | input | N_DIFF | Per-output enable pins |
| pll_lock_i | input | 1 | PLL lock indication |
| addr_sel_i | input | 1 | Slave-address select pin |
| ss_pin_i | input | 2 | Three-level spread select pin, encoded |
| cfg_oe_i | input | N_DIFF | Register enable bit per differential output |
| cfg_park_lvl_i | input | 2 | Park levels: bit 0 true, bit 1 complement |
| cfg_ref_pd_run_i | input | 1 | Keep reference running in power-down |
| cfg_ss_from_reg_i | input | 1 | 1 = spread from register, 0 = from pin |
| cfg_ss_i | input | 2 | Register spread code |
| bclk_gate_o | output | N_DIFF | Clock gate enable per differential output |
| bclk_mode_o | output | 2*N_DIFF | Drive mode per differential output |
| bclk_lvl_o | output | 2*N_DIFF | Static true/complement levels per output |
| ref_gate_o | output | 1 | Clock gate enable of the reference output |
| ref_mode_o | output | 2 | Drive mode of the reference output |
| addr_o | output | 7 | Latched slave address |
| spread_o | output | 2 | Selected spread code |

## Verification
The first synchronized power-good has three effects. It captures the address, it releases the reference from high-impedance, and in the same falling edge it moves the differential outputs out of park. The bench provokes this by raising `pwrgd_i` with `addr_sel_i` at 1, the lock low and both enables high, all in one cycle. A behavioural model then judges every clock: the reference must leave high-impedance in the same cycle that the outputs turn off, and the new address must appear exactly one cycle later. A second reset followed by a power-good with the other address level confirms that the capture happens again.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  typedef enum logic [1:0] {
    DM_OFF  = 2'b00,
    DM_RUN  = 2'b01,
    DM_PARK = 2'b10,
    DM_HIZ  = 2'b11
  } drv_mode_e;

  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] ADDR_LO = 7'b1101000;
  localparam logic [ADDR_W-1:0] ADDR_HI = 7'b1101010;

  function automatic logic [1:0] spread_norm(input logic [1:0] code);
    return (code == 2'b11) ? 2'b00 : code;
  endfunction

endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/clkpm_out_gate.sv
module clkpm_out_gate
  import clkpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg,
  input  logic       lock,
  input  logic       oe_pin,
  input  logic       cfg_oe,
  input  logic [1:0] park_lvl,
  output logic [1:0] mode,
  output logic [1:0] lvl,
  output logic       gate
);

  drv_mode_e  mode_d, mode_q;
  logic [1:0] lvl_d, lvl_q;
  logic       upd;

  always_comb begin
    lvl_d = 2'b00;
    if (!pg) begin
      mode_d = DM_PARK;
      lvl_d  = park_lvl;
    end else if (!lock) begin
      mode_d = DM_OFF;
    end else if (oe_pin && cfg_oe) begin
      mode_d = DM_RUN;
    end else begin
      mode_d = DM_OFF;
    end
  end

  assign upd = (mode_d != mode_q) || (lvl_d != lvl_q);

  // falling edge: gate changes only while the clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DM_PARK;
      lvl_q  <= 2'b00;
    end else if (upd) begin
      mode_q <= mode_d;
      lvl_q  <= lvl_d;
    end
  end

  assign mode = mode_q;
  assign lvl  = lvl_q;
  assign gate = (mode_q == DM_RUN);

endmodule

// File: rtl/clkpm_ref_addr.sv
module clkpm_ref_addr
  import clkpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg,
  input  logic              addr_sel,
  input  logic              pd_run,
  output logic [1:0]        ref_mode,
  output logic              ref_gate,
  output logic [ADDR_W-1:0] addr
);

  logic              seen_q, seen_d;
  logic              capture;
  logic [ADDR_W-1:0] addr_q, addr_d;
  drv_mode_e         ref_d, ref_q;

  assign capture = pg && !seen_q;

  always_comb begin
    seen_d = seen_q | pg;
    addr_d = addr_q;
    if (capture) addr_d = addr_sel ? ADDR_HI : ADDR_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      addr_q <= ADDR_LO;
    end else if (capture) begin
      seen_q <= seen_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    if (!(seen_q || pg)) ref_d = DM_HIZ;
    else if (pg)         ref_d = DM_RUN;
    else if (pd_run)     ref_d = DM_RUN;
    else                 ref_d = DM_OFF;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= DM_HIZ;
    else if (ref_d != ref_q) ref_q <= ref_d;
  end

  assign ref_mode = ref_q;
  assign ref_gate = (ref_q == DM_RUN);
  assign addr     = addr_q;

endmodule

// File: rtl/clkout_pwr_ctrl.sv
module clkout_pwr_ctrl
  import clkpm_pkg::*;
#(
  parameter int N_DIFF      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwrgd_i,
  input  logic [N_DIFF-1:0]     oe_pin_i,
  input  logic                  pll_lock_i,
  input  logic                  addr_sel_i,
  input  logic [1:0]            ss_pin_i,
  input  logic [N_DIFF-1:0]     cfg_oe_i,
  input  logic [1:0]            cfg_park_lvl_i,
  input  logic                  cfg_ref_pd_run_i,
  input  logic                  cfg_ss_from_reg_i,
  input  logic [1:0]            cfg_ss_i,
  output logic [N_DIFF-1:0]     bclk_gate_o,
  output logic [2*N_DIFF-1:0]   bclk_mode_o,
  output logic [2*N_DIFF-1:0]   bclk_lvl_o,
  output logic                  ref_gate_o,
  output logic [1:0]            ref_mode_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [1:0]            spread_o
);

  localparam int PIN_W = N_DIFF + 5;

  logic             rst_int_n;
  logic [PIN_W-1:0] pin_raw, pin_s;
  logic             pg_s, lock_s, asel_s;
  logic [N_DIFF-1:0] oe_s;
  logic [1:0]       ss_s;

  // reset: asserted asynchronously, released on the clock
  clkpm_sync #(.WIDTH(1), .STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  assign pin_raw = {addr_sel_i, ss_pin_i, pll_lock_i, oe_pin_i, pwrgd_i};

  clkpm_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pin_raw), .q(pin_s)
  );

  assign pg_s   = pin_s[0];
  assign oe_s   = pin_s[N_DIFF:1];
  assign lock_s = pin_s[N_DIFF+1];
  assign ss_s   = pin_s[N_DIFF+3:N_DIFF+2];
  assign asel_s = pin_s[N_DIFF+4];

  for (genvar i = 0; i < N_DIFF; i++) begin : g_out
    clkpm_out_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .pg       (pg_s),
      .lock     (lock_s),
      .oe_pin   (oe_s[i]),
      .cfg_oe   (cfg_oe_i[i]),
      .park_lvl (cfg_park_lvl_i),
      .mode     (bclk_mode_o[2*i+1:2*i]),
      .lvl      (bclk_lvl_o[2*i+1:2*i]),
      .gate     (bclk_gate_o[i])
    );
  end

  clkpm_ref_addr u_ref (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pg       (pg_s),
    .addr_sel (asel_s),
    .pd_run   (cfg_ref_pd_run_i),
    .ref_mode (ref_mode_o),
    .ref_gate (ref_gate_o),
    .addr     (addr_o)
  );

  assign spread_o = spread_norm(cfg_ss_from_reg_i ? cfg_ss_i : ss_s);

endmodule

// File: rtl/clkpm_chk.sv
module clkpm_chk #(
  parameter int N_DIFF = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*N_DIFF-1:0] bclk_mode_o,
  input logic [2*N_DIFF-1:0] bclk_lvl_o,
  input logic [1:0]          ref_mode_o,
  input logic [6:0]          addr_o,
  input logic [1:0]          spread_o,
  input logic                cfg_ref_pd_run_i
);

  // R2
  ref_stays_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_mode_o != 2'b11) |=> (ref_mode_o != 2'b11));

  // R1
  addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_o == 7'b1101000) || (addr_o == 7'b1101010));

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ref_mode_o != 2'b11) && $past(ref_mode_o != 2'b11, 2)) |-> $stable(addr_o));

  // R10
  spread_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spread_o != 2'b11);

  // R3
  ref_pd_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bclk_mode_o[1:0] == 2'b10) && (ref_mode_o == 2'b01)) |-> cfg_ref_pd_run_i);

  for (genvar i = 0; i < N_DIFF; i++) begin : g_chk
    // R5
    lvl_only_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bclk_mode_o[2*i+1:2*i] != 2'b10) |-> (bclk_lvl_o[2*i+1:2*i] == 2'b00));
    // R7
    diff_no_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bclk_mode_o[2*i+1:2*i] != 2'b11);
  end

endmodule

bind clkout_pwr_ctrl clkpm_chk #(.N_DIFF(N_DIFF)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bclk_mode_o      (bclk_mode_o),
  .bclk_lvl_o       (bclk_lvl_o),
  .ref_mode_o       (ref_mode_o),
  .addr_o           (addr_o),
  .spread_o         (spread_o),
  .cfg_ref_pd_run_i (cfg_ref_pd_run_i)
);

// File: tb/clkout_pwr_ctrl_test.sv
module clkout_pwr_ctrl_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       pg;
    logic [1:0] oe;
    logic       lock;
    logic       sadr;
    logic [1:0] ss;
  } stim_t;

  logic clk, rst_n;
  logic pwrgd, lock, asel;
  logic [1:0] oe, ss;
  logic [1:0] d_oe, d_lvl, d_ss;
  logic d_refrun, d_ssel;
  logic [1:0] n_oe, n_lvl, n_ss;
  logic n_refrun, n_ssel;

  logic [1:0] bclk_gate;
  logic [3:0] bclk_mode, bclk_lvl;
  logic ref_gate;
  logic [1:0] ref_mode, spread;
  logic [6:0] addr;

  int n_chk, n_fail;
  stim_t pq[$];
  bit seen_m;
  logic [6:0] addr_m;
  logic [15:0] lf;

  clkout_pwr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pwrgd_i(pwrgd), .oe_pin_i(oe), .pll_lock_i(lock),
    .addr_sel_i(asel), .ss_pin_i(ss), .cfg_oe_i(d_oe), .cfg_park_lvl_i(d_lvl),
    .cfg_ref_pd_run_i(d_refrun), .cfg_ss_from_reg_i(d_ssel), .cfg_ss_i(d_ss),
    .bclk_gate_o(bclk_gate), .bclk_mode_o(bclk_mode), .bclk_lvl_o(bclk_lvl),
    .ref_gate_o(ref_gate), .ref_mode_o(ref_mode), .addr_o(addr), .spread_o(spread)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic stim_t mk(logic p, logic [1:0] o, logic l, logic a, logic [1:0] s);
    stim_t t;
    t.pg = p; t.oe = o; t.lock = l; t.sadr = a; t.ss = s;
    return t;
  endfunction

  function automatic logic [1:0] sn(logic [1:0] v);
    return (v == 2'b11) ? 2'b00 : v;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0;
    {pwrgd, oe, lock, asel, ss} = '0;
    n_oe = 2'b11; n_lvl = 2'b00; n_ss = 2'b00; n_refrun = 1'b0; n_ssel = 1'b0;
    d_oe = n_oe; d_lvl = n_lvl; d_ss = n_ss; d_refrun = n_refrun; d_ssel = n_ssel;
    repeat (3) @(posedge clk);
    #1;
    // reset state
    chk({tag, " ref hiz"}, {14'd0, ref_mode}, 16'h3);
    chk("R1 reset addr", {9'd0, addr}, 16'h68);
    chk("R5 reset mode", {12'd0, bclk_mode}, 16'hA);
    chk("R5 reset lvl", {12'd0, bclk_lvl}, 16'h0);
    chk("R8 reset gates", {13'd0, ref_gate, bclk_gate}, 16'h0);
    chk("R10 reset spread", {14'd0, spread}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    pq.delete();
    pq.push_back('0);
    pq.push_back('0);
    seen_m = 1'b0;
    addr_m = 7'h68;
  endtask

  task automatic step(input stim_t s);
    stim_t d;
    logic [1:0] ref_e, m, l;
    logic [3:0] mode_e, lvl_e;
    logic [1:0] gate_e;
    string dtag, rtag;
    @(posedge clk);
    #1;
    pwrgd = s.pg; oe = s.oe; lock = s.lock; asel = s.sadr; ss = s.ss;
    d_oe = n_oe; d_lvl = n_lvl; d_ss = n_ss; d_refrun = n_refrun; d_ssel = n_ssel;
    pq.push_back(s);
    #(CLK_PERIOD-2);
    d = pq.pop_front();
    if (!(seen_m || d.pg)) begin ref_e = 2'b11; rtag = "R2"; end
    else if (d.pg)         begin ref_e = 2'b01; rtag = "R4"; end
    else begin ref_e = d_refrun ? 2'b01 : 2'b00; rtag = "R3"; end
    for (int i = 0; i < 2; i++) begin
      l = 2'b00;
      if (!d.pg) begin m = 2'b10; l = d_lvl; dtag = "R5"; end
      else if (!d.lock) begin m = 2'b00; dtag = "R7"; end
      else begin m = (d.oe[i] && d_oe[i]) ? 2'b01 : 2'b00; dtag = "R6"; end
      mode_e[2*i +: 2] = m;
      lvl_e[2*i +: 2]  = l;
      gate_e[i] = (m == 2'b01);
    end
    chk({rtag, "/R9 ref mode"}, {14'd0, ref_mode}, {14'd0, ref_e});
    chk({dtag, "/R9 diff mode"}, {12'd0, bclk_mode}, {12'd0, mode_e});
    chk({dtag, " diff lvl"}, {12'd0, bclk_lvl}, {12'd0, lvl_e});
    chk("R8 gates", {13'd0, ref_gate, bclk_gate}, {13'd0, ref_e == 2'b01, gate_e});
    chk("R10 spread", {14'd0, spread}, {14'd0, sn(d_ssel ? d_ss : d.ss)});
    chk("R1 addr", {9'd0, addr}, {9'd0, addr_m});
    if (d.pg && !seen_m) addr_m = d.sadr ? 7'h6A : 7'h68;
    seen_m = seen_m | d.pg;
  endtask

  task automatic rnd_steps(input int n);
    for (int k = 0; k < n; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'h5) begin
        n_oe = lf[5:4]; n_lvl = lf[7:6]; n_refrun = lf[8];
        n_ssel = lf[9]; n_ss = lf[11:10];
      end
      step(mk(lf[15] | lf[14], lf[13:12], lf[11] | lf[2], lf[1], lf[9:8]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; lf = 16'hACE1;
    do_reset("R2");
    // R2 R5: power-down before any power-good, park levels follow the register
    n_lvl = 2'b01;
    repeat (4) step(mk(1'b0, 2'b11, 1'b1, 1'b1, 2'b00));
    n_lvl = 2'b10;
    repeat (3) step(mk(1'b0, 2'b11, 1'b1, 1'b1, 2'b00));
    // R1 R2 R4 R7: first power-good, address pin high, lock still low
    repeat (5) step(mk(1'b1, 2'b11, 1'b0, 1'b1, 2'b00));
    // R6 R8: every pin/register enable combination, address pin now low (R1 ignored)
    for (int c = 0; c < 4; c++) begin
      n_oe = c[1:0];
      for (int p = 0; p < 4; p++) repeat (3) step(mk(1'b1, p[1:0], 1'b1, 1'b0, 2'b00));
    end
    // R10: spread from pin, then from register
    n_oe = 2'b11;
    for (int v = 0; v < 4; v++) repeat (3) step(mk(1'b1, 2'b11, 1'b1, 1'b0, v[1:0]));
    n_ssel = 1'b1;
    for (int v = 0; v < 4; v++) begin
      n_ss = v[1:0];
      repeat (2) step(mk(1'b1, 2'b11, 1'b1, 1'b0, 2'b10));
    end
    n_ssel = 1'b0;
    // R3: power-down after first power-good, with and without reference override
    n_lvl = 2'b11; n_refrun = 1'b0;
    repeat (4) step(mk(1'b0, 2'b11, 1'b1, 1'b0, 2'b00));
    n_refrun = 1'b1;
    repeat (4) step(mk(1'b0, 2'b11, 1'b1, 1'b0, 2'b00));
    repeat (3) step(mk(1'b1, 2'b11, 1'b1, 1'b0, 2'b00));
    rnd_steps(200);
    chk("R1 address kept after power cycles", {9'd0, addr}, 16'h6A);
    // R11: a new reset brings back high-impedance and a fresh capture
    do_reset("R11");
    repeat (5) step(mk(1'b1, 2'b01, 1'b1, 1'b0, 2'b01));
    chk("R11 address recaptured", {9'd0, addr}, 16'h68);
    rnd_steps(150);
    summary();
    $finish;
  end

endmodule